// File: doc/BRIEF.md
# Dual-Channel Reloadable Down-Counter Timer

This block holds two identical down-counting timer channels behind a small register port. Each channel draws its count tick from a source that a 4-bit select field picks. The source can be a fixed low-rate tick or one of eight external pulse inputs. The block builds the fixed tick by dividing its own clock, which is the crystal reference. With a 24 MHz reference and the default divisor of 750, the fixed tick runs at exactly 32 kHz. A divisor of 768 would give 31.25 kHz instead.

Software writes a 16-bit period value, called the fixed count. With the update bit set, that write also loads the running counter at once. Each expiry sets a sticky status bit. With reload set, the counter refills from the fixed count and keeps running, which gives a periodic tick such as a scheduler interrupt. Without reload, the counter stops at zero. The interrupt line of a channel is its status bit gated by the channel's interrupt enable.

A common setup runs one channel as the system tick, loaded with rate/HZ - 1. The other channel runs free with a fixed count of 0xFFFF.

Top module: `tmr_top`

## Requirements
- R1: The fixed tick fires once every DIV clock cycles (DIV is a parameter, default 750). A channel whose select field is 11 (0xB) counts that tick, so a channel loaded with N expires every (N+1)*DIV cycles.
- R2: Select values 1 to 8 pick external input extIn[sel-1], so 8 picks extIn[7]. Each input passes through a two-flip-flop synchroniser. Each rising edge gives exactly one tick, and the other inputs have no effect.
- R3: With select 0, or with an unassigned select value (9, 10, 12 to 15), the running count does not change on any tick source.
- R4: Register map: regAddr[2] is the channel and regAddr[1:0] is the register. Register 0 is control: bits 3:0 select, bit 4 reload, bit 5 update, bit 6 interrupt enable. Register 1 is the fixed count, register 2 the running count (read only) and register 3 the status (bit 0). A fixed-count write with update set loads the running count on the next cycle. With update clear, the write leaves the running count as it was.
- R5: Each tick lowers the running count by one. After a load of N, the expiry happens on tick N+1, while the count is 0, and not before.
- R6: With reload set, an expiry copies the fixed count into the running count and counting goes on, so expiries repeat every N+1 ticks.
- R7: With reload clear, the count stays at 0 after an expiry, and further ticks cause no more expiries until the counter is loaded again.
- R8: An expiry sets the channel's status bit. Only writing 1 to status bit 0 clears it, and writing 0 leaves it set.
- R9: irq[c] is high exactly when channel c's status bit is set and its interrupt enable is set.
- R10: The channels are independent: ticks, loads and clears on one channel leave the other channel's count and status unchanged.
- R11: After reset, every count, fixed count, control field and status bit is zero, and irq is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock, also the divider input |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 3 | Register address: {channel, register} |
| regWrData | input | 16 | Register write data |
| regRdData | output | 16 | Read data for regAddr (combinational) |
| extIn | input | 8 | External pulse inputs, asynchronous |
| irq | output | 2 | Per-channel interrupt line |

## Verification
The assertions check the following on every cycle:
- An update write lands in the running count.
- The count never steps by more than one except on a load or a reload.
- A select of 0 freezes the count.
- A zero count without reload stays at zero.
- The status bit falls only after a write-one-to-clear.
- The interrupt stays low while it is disabled.

Only the bench scenarios can show that the external edges are steered to the right channel through the select decode, and that the expiry lands on exactly the N+1th tick. The bench scenarios also show that the fixed tick divides the clock by the divisor, and that the two channels stay independent.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int SEL_W  = 4;
  localparam int CNT_W  = 16;
  localparam int DATA_W = 16;

  localparam logic [SEL_W-1:0] SEL_OFF   = 4'd0;
  localparam logic [SEL_W-1:0] SEL_FIXED = 4'hB;

  localparam logic [1:0] REG_CTRL   = 2'd0;
  localparam logic [1:0] REG_FIXED  = 2'd1;
  localparam logic [1:0] REG_COUNT  = 2'd2;
  localparam logic [1:0] REG_STATUS = 2'd3;

  typedef struct packed {
    logic             irqEn;
    logic             update;
    logic             reload;
    logic [SEL_W-1:0] sel;
  } chCtrl_t;

  typedef struct packed {
    logic tick;
    logic wrFixed;
    logic loadRun;
    logic reload;
    logic clrStatus;
  } chStrobe_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int DIV = 750
) (
  input  logic clk,
  input  logic rstN,
  output logic fixedTick
);
  localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [PW-1:0] LAST = PW'(DIV - 1);

  logic [PW-1:0] divCnt;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      divCnt <= '0;
    end else if (divCnt == LAST) begin
      divCnt <= '0;
    end else begin
      divCnt <= divCnt + 1'b1;
    end
  end

  assign fixedTick = (divCnt == LAST);
endmodule

// File: rtl/tmr_sync.sv
module tmr_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] risePulse
);
  logic [W-1:0] meta;
  logic [W-1:0] stable;
  logic [W-1:0] last;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      meta   <= '0;
      stable <= '0;
      last   <= '0;
    end else begin
      meta   <= asyncIn;
      stable <= meta;
      last   <= stable;
    end
  end

  assign risePulse = stable & ~last;
endmodule

// File: rtl/tmr_ctrl.sv
module tmr_ctrl
  import tmr_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int NEXT = 8,
  parameter int AW   = $clog2(NCH) + 2
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        regWrEn,
  input  logic [AW-1:0]               regAddr,
  input  logic [DATA_W-1:0]           regWrData,
  input  logic                        fixedTick,
  input  logic [NEXT-1:0]             extRise,
  input  logic [NCH-1:0][CNT_W-1:0]   countQ,
  input  logic [NCH-1:0][CNT_W-1:0]   fixedQ,
  input  logic [NCH-1:0]              statusQ,
  output chCtrl_t [NCH-1:0]           ctrlQ,
  output chStrobe_t [NCH-1:0]         strobe,
  output logic [DATA_W-1:0]           regRdData
);
  localparam int CHW = AW - 2;

  logic [CHW-1:0] chSel;
  logic [1:0]     regSel;

  assign chSel  = regAddr[AW-1:2];
  assign regSel = regAddr[1:0];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic chHit;
    logic chTick;

    assign chHit = regWrEn && (chSel == CHW'(c));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        ctrlQ[c] <= '0;
      end else if (chHit && regSel == REG_CTRL) begin
        ctrlQ[c].sel    <= regWrData[SEL_W-1:0];
        ctrlQ[c].reload <= regWrData[4];
        ctrlQ[c].update <= regWrData[5];
        ctrlQ[c].irqEn  <= regWrData[6];
      end
    end

    always_comb begin
      chTick = 1'b0;
      if (ctrlQ[c].sel == SEL_FIXED) begin
        chTick = fixedTick;
      end else begin
        for (int k = 0; k < NEXT; k++) begin
          if (ctrlQ[c].sel == SEL_W'(k + 1)) chTick = extRise[k];
        end
      end
    end

    assign strobe[c].tick      = chTick;
    assign strobe[c].wrFixed   = chHit && (regSel == REG_FIXED);
    assign strobe[c].loadRun   = chHit && (regSel == REG_FIXED) && ctrlQ[c].update;
    assign strobe[c].reload    = ctrlQ[c].reload;
    assign strobe[c].clrStatus = chHit && (regSel == REG_STATUS) && regWrData[0];
  end

  always_comb begin
    regRdData = '0;
    for (int c = 0; c < NCH; c++) begin
      if (chSel == CHW'(c)) begin
        unique case (regSel)
          REG_CTRL:   regRdData = DATA_W'({ctrlQ[c].irqEn, ctrlQ[c].update,
                                           ctrlQ[c].reload, ctrlQ[c].sel});
          REG_FIXED:  regRdData = DATA_W'(fixedQ[c]);
          REG_COUNT:  regRdData = DATA_W'(countQ[c]);
          REG_STATUS: regRdData = DATA_W'(statusQ[c]);
          default:    regRdData = '0;
        endcase
      end
    end
  end
endmodule

// File: rtl/tmr_datapath.sv
module tmr_datapath
  import tmr_pkg::*;
#(
  parameter int NCH = 2
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  chStrobe_t [NCH-1:0]       strobe,
  input  logic [DATA_W-1:0]         wrData,
  output logic [NCH-1:0][CNT_W-1:0] countQ,
  output logic [NCH-1:0][CNT_W-1:0] fixedQ,
  output logic [NCH-1:0]            statusQ
);
  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic armed;
    logic expire;

    assign expire = strobe[c].tick && armed && (countQ[c] == '0) && !strobe[c].loadRun;

    always_ff @(posedge clk) begin
      if (!rstN) begin
        fixedQ[c] <= '0;
        countQ[c] <= '0;
        armed     <= 1'b0;
      end else begin
        if (strobe[c].wrFixed) fixedQ[c] <= wrData[CNT_W-1:0];
        if (strobe[c].loadRun) begin
          countQ[c] <= wrData[CNT_W-1:0];
          armed     <= 1'b1;
        end else if (strobe[c].tick && armed) begin
          if (countQ[c] != '0) begin
            countQ[c] <= countQ[c] - 1'b1;
          end else if (strobe[c].reload) begin
            countQ[c] <= fixedQ[c];
          end else begin
            armed <= 1'b0;
          end
        end
      end
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statusQ[c] <= 1'b0;
      end else if (expire) begin
        statusQ[c] <= 1'b1;
      end else if (strobe[c].clrStatus) begin
        statusQ[c] <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int NCH  = 2,
  parameter int NEXT = 8,
  parameter int DIV  = 750,
  parameter int AW   = $clog2(NCH) + 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [AW-1:0]     regAddr,
  input  logic [DATA_W-1:0] regWrData,
  output logic [DATA_W-1:0] regRdData,
  input  logic [NEXT-1:0]   extIn,
  output logic [NCH-1:0]    irq
);
  logic                      fixedTick;
  logic [NEXT-1:0]           extRise;
  chCtrl_t [NCH-1:0]         ctrlQ;
  chStrobe_t [NCH-1:0]       strobe;
  logic [NCH-1:0][CNT_W-1:0] countQ;
  logic [NCH-1:0][CNT_W-1:0] fixedQ;
  logic [NCH-1:0]            statusQ;

  tmr_prescaler #(.DIV(DIV)) u_pre (
    .clk(clk), .rstN(rstN), .fixedTick(fixedTick)
  );

  tmr_sync #(.W(NEXT)) u_sync (
    .clk(clk), .rstN(rstN), .asyncIn(extIn), .risePulse(extRise)
  );

  tmr_ctrl #(.NCH(NCH), .NEXT(NEXT), .AW(AW)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .fixedTick(fixedTick), .extRise(extRise),
    .countQ(countQ), .fixedQ(fixedQ), .statusQ(statusQ),
    .ctrlQ(ctrlQ), .strobe(strobe), .regRdData(regRdData)
  );

  tmr_datapath #(.NCH(NCH)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wrData(regWrData),
    .countQ(countQ), .fixedQ(fixedQ), .statusQ(statusQ)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_irq
    assign irq[c] = statusQ[c] & ctrlQ[c].irqEn;
  end
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
  import tmr_pkg::*;
#(
  parameter int NCH = 2,
  parameter int AW  = $clog2(NCH) + 2
) (
  input logic                      clk,
  input logic                      rstN,
  input logic                      regWrEn,
  input logic [AW-1:0]             regAddr,
  input logic [DATA_W-1:0]         regWrData,
  input logic [NCH-1:0]            irq,
  input chCtrl_t [NCH-1:0]         ctrlQ,
  input logic [NCH-1:0][CNT_W-1:0] countQ,
  input logic [NCH-1:0][CNT_W-1:0] fixedQ,
  input logic [NCH-1:0]            statusQ
);
  localparam int CHW = AW - 2;

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    logic wrFix;
    logic wrClr;
    assign wrFix = regWrEn && regAddr[AW-1:2] == CHW'(c) && regAddr[1:0] == REG_FIXED;
    assign wrClr = regWrEn && regAddr[AW-1:2] == CHW'(c) && regAddr[1:0] == REG_STATUS
                   && regWrData[0];

    AST_UPDATE_LOADS: assert property (@(posedge clk) disable iff (!rstN)
      (wrFix && ctrlQ[c].update) |=> countQ[c] == $past(regWrData[CNT_W-1:0])); // R4
    AST_SEL_OFF_FROZEN: assert property (@(posedge clk) disable iff (!rstN)
      (ctrlQ[c].sel == SEL_OFF && !wrFix) |=> $stable(countQ[c])); // R3
    AST_STEP_BY_ONE: assert property (@(posedge clk) disable iff (!rstN)
      (!wrFix && countQ[c] != '0) |=>
        (countQ[c] == $past(countQ[c]) || countQ[c] == CNT_W'($past(countQ[c]) - 1'b1))); // R5
    AST_HALT_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      (!wrFix && countQ[c] == '0 && !ctrlQ[c].reload) |=> countQ[c] == '0); // R7
    AST_RELOAD_VALUE: assert property (@(posedge clk) disable iff (!rstN)
      (!wrFix && countQ[c] == '0 && ctrlQ[c].reload) |=>
        (countQ[c] == '0 || countQ[c] == $past(fixedQ[c]))); // R6
    AST_STATUS_W1C_ONLY: assert property (@(posedge clk) disable iff (!rstN)
      $fell(statusQ[c]) |-> $past(wrClr)); // R8
    AST_STATUS_AT_ZERO: assert property (@(posedge clk) disable iff (!rstN)
      $rose(statusQ[c]) |-> $past(countQ[c] == '0)); // R5
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rstN)
      !ctrlQ[c].irqEn |-> !irq[c]); // R9
  end
endmodule

bind tmr_top tmr_checker #(.NCH(NCH), .AW(AW)) u_chk (
  .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
  .regWrData(regWrData), .irq(irq), .ctrlQ(ctrlQ), .countQ(countQ),
  .fixedQ(fixedQ), .statusQ(statusQ)
);

// File: tb/tb_tmr_top.sv
module tb_tmr_top;
  localparam int DIV = 750;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regAddr = '0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic [7:0]  extIn = '0;
  logic [1:0]  irq;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  always #5 clk = ~clk;

  tmr_top #(.NCH(2), .NEXT(8), .DIV(DIV)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData), .extIn(extIn), .irq(irq)
  );

  function automatic logic [15:0] ctl(int sel, bit rl, bit up, bit ie);
    return 16'(sel) | (16'(rl) << 4) | (16'(up) << 5) | (16'(ie) << 6);
  endfunction

  task automatic check(string req, int got, int exp);
    checks++;
    if (got != exp) begin
      failures++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic wr(int a, logic [15:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 3'(a); regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(int a, output int v);
    @(negedge clk);
    regAddr = 3'(a);
    #1 v = int'(regRdData);
  endtask

  task automatic pulse(int b);
    @(negedge clk); extIn[b] = 1'b1;
    repeat (2) @(negedge clk);
    extIn[b] = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  task automatic t_reset();
    int v;
    rd(2, v); check("R11 count0", v, 0);
    rd(3, v); check("R11 status0", v, 0);
    rd(6, v); check("R11 count1", v, 0);
    rd(0, v); check("R11 ctrl0", v, 0);
    check("R11 irq", int'(irq), 0);
  endtask

  task automatic t_update();
    int v;
    wr(0, ctl(0, 0, 1, 0)); wr(1, 16'd5);
    rd(2, v); check("R4 update load", v, 5);
    wr(0, ctl(0, 0, 0, 0)); wr(1, 16'd9);
    rd(2, v); check("R4 no update keeps count", v, 5);
    rd(1, v); check("R4 fixed written", v, 9);
  endtask

  task automatic t_ext();
    int v;
    wr(0, ctl(3, 0, 0, 0));
    pulse(2); pulse(2);
    rd(2, v); check("R2 sel3 two edges", v, 3);
    pulse(4); pulse(0);
    rd(2, v); check("R2 other inputs ignored", v, 3);
    wr(0, ctl(8, 0, 0, 0));
    pulse(7);
    rd(2, v); check("R2 sel8 picks input 7", v, 2);
  endtask

  task automatic t_stop();
    int v;
    wr(0, ctl(0, 0, 0, 0));
    pulse(7); pulse(0);
    rd(2, v); check("R3 sel0 frozen", v, 2);
    wr(0, ctl(9, 0, 0, 0));
    for (int b = 0; b < 8; b++) pulse(b);
    repeat (DIV + 50) @(negedge clk);
    rd(2, v); check("R3 sel9 frozen", v, 2);
    wr(0, ctl(13, 0, 0, 0));
    pulse(0);
    repeat (DIV + 50) @(negedge clk);
    rd(2, v); check("R3 sel13 frozen", v, 2);
  endtask

  task automatic t_noreload();
    int v;
    wr(0, ctl(1, 0, 1, 0)); wr(1, 16'd2);
    pulse(0); pulse(0);
    rd(2, v); check("R5 count at zero", v, 0);
    rd(3, v); check("R5 no expiry before N+1", v, 0);
    pulse(0);
    rd(3, v); check("R5 expiry on tick N+1", v, 1);
    pulse(0); pulse(0);
    rd(2, v); check("R7 stays at zero", v, 0);
    wr(3, 16'd1);
    pulse(0);
    rd(3, v); check("R7 no further expiry", v, 0);
  endtask

  task automatic t_w1c();
    int v;
    wr(1, 16'd0);
    pulse(0);
    rd(3, v); check("R8 set on expiry", v, 1);
    wr(3, 16'd0);
    rd(3, v); check("R8 write 0 keeps", v, 1);
    wr(3, 16'd1);
    rd(3, v); check("R8 write 1 clears", v, 0);
  endtask

  task automatic t_reload();
    int v;
    wr(0, ctl(1, 1, 1, 0)); wr(1, 16'd1);
    pulse(0);
    rd(2, v); check("R6 down to 0", v, 0);
    pulse(0);
    rd(2, v); check("R6 reloaded", v, 1);
    rd(3, v); check("R6 expiry flagged", v, 1);
    pulse(0); pulse(0);
    rd(2, v); check("R6 periodic", v, 1);
  endtask

  task automatic t_irq();
    @(negedge clk); check("R9 masked", int'(irq[0]), 0);
    wr(0, ctl(1, 1, 1, 1));
    @(negedge clk); check("R9 enabled", int'(irq[0]), 1);
    wr(3, 16'd1);
    @(negedge clk); check("R9 after clear", int'(irq[0]), 0);
  endtask

  task automatic t_indep();
    int v;
    wr(4, ctl(2, 0, 1, 1)); wr(5, 16'hFFFF);
    pulse(0); pulse(0);
    rd(6, v); check("R10 ch1 untouched", v, 16'hFFFF);
    pulse(1);
    rd(6, v); check("R10 ch1 counts", v, 16'hFFFE);
    rd(7, v); check("R10 ch1 status", v, 0);
    check("R10 irq1", int'(irq[1]), 0);
  endtask

  task automatic t_fixed();
    int cyc;
    int guard;
    wr(0, ctl(11, 1, 1, 1)); wr(1, 16'd2); wr(3, 16'd1);
    guard = 0;
    while (irq[0] !== 1'b1 && guard < 5*DIV) begin @(negedge clk); guard++; end
    check("R1 first expiry seen", int'(irq[0]), 1);
    regWrEn = 1'b1; regAddr = 3'd3; regWrData = 16'd1;
    @(negedge clk);
    regWrEn = 1'b0;
    cyc = 1;
    check("R1 cleared", int'(irq[0]), 0);
    while (irq[0] !== 1'b1 && cyc < 5*DIV) begin @(negedge clk); cyc++; end
    check("R1 period 3*DIV", cyc, 3*DIV);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_update();
    t_ext();
    t_stop();
    t_noreload();
    t_w1c();
    t_reload();
    t_irq();
    t_indep();
    t_fixed();
    done = 1;
  end

  initial begin
    int n;
    n = 0;
    while (!done && n < 150000) begin @(posedge clk); n++; end
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog: got %0d cycles expected completion", n);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule